// File: doc/BRIEF.md
# Multichannel SPI Channel Transfer Controller

This block runs up to four SPI master channels behind a simple 32-bit register bus. Each channel keeps its own configuration, status and enable state, one transmit holding register and one receive holding register. One shift engine moves a single word at a time, and all channels share it. The engine drives SCK, MOSI and one active-low chip select for each channel. Software or a DMA engine fills the transmit holding register and empties the receive holding register. Status flags and per-channel DMA request lines pace that traffic.

A channel asks for the shift engine whenever it is enabled and its handshake conditions are met. Each channel has a transfer-mode field that can ignore the receive side or the transmit side of the handshake. A turbo bit lets the next word start while the previous received word is still unread. When several channels are ready at the same moment, the lowest-numbered channel goes first. Word length can be set from 4 to 32 bits. Bits are shifted MSB first with SCK idle low.

Top module: `spi_chan_ctrl`

## Requirements
- R1: After reset every channel configuration reads 0x060000, every status reads 0x2, every enable is 0, SCK is low, all chip selects are high and all DMA requests are low.
- R2: Configuration bits 11:7 hold a length code L, and a word moves L+1 bits MSB first. Codes below 3 act as 3, so the shortest word is 4 bits. The received word is right-aligned in the receive register.
- R3: Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-word. When a word completes, end-of-word and transmit-empty are set, and receive-full is set unless the mode is transmit-only. End-of-word clears when that channel's next word starts.
- R4: A word starts only when control bit 0 (enable) is 1. Receive-full blocks a start unless the mode field (configuration bits 13:12: 0 both, 1 receive-only, 2 transmit-only) is 2 or turbo (configuration bit 19) is set. Transmit-empty blocks a start unless the mode is 1.
- R5: Writing the transmit register clears transmit-empty, and reading the receive register clears receive-full. A channel that meets R4 starts as soon as the engine is free, including right after it is enabled.
- R6: The transmit DMA request is enable AND configuration bit 14 AND transmit-empty AND mode not 1. The receive DMA request is enable AND configuration bit 15 AND receive-full AND mode not 2.
- R7: Only configuration bits 22:0 are stored. Writes to the status and receive registers change nothing.
- R8: A channel's chip select goes low during that channel's word when module control bit 0 (offset 0x28) is 0 or the channel's force bit (configuration bit 20) is 1. At all other times it is high.
- R9: Only one word is in flight at a time, so at most one chip select is low. Among ready channels the lowest index is served first.
- R10: SCK idles low and has a period of CLK_DIV clocks. MOSI changes only on SCK falling edges, and MISO is sampled on rising edges.
- R11: Channel i sits at 0x2C + 0x14*i with configuration +0x0, status +0x4, control +0x8, transmit +0xC and receive +0x10. Module control is at 0x28. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| sck_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CH | Chip selects, active low |
| tx_dreq_o | output | NUM_CH | Transmit DMA requests |
| rx_dreq_o | output | NUM_CH | Receive DMA requests |

## Verification
The bench targets the gating rules. It checks that an unread receive word stalls a new transmit write, that turbo and transmit-only mode lift that stall, and that receive-only mode starts on enable alone and then stops on its own unread data. A design that mixed up the mode masks would stall forever or overrun unread data, and those tests show it. The bench also loads an illegal length code and checks that it shifts four bits, not one or two. It queues two channels behind a busy third one and checks the service order from the chip-select sequence. A wrong priority encoder shows up as the wrong order. A DMA request that does not drop on the access that services it shows up one cycle after that access.

// File: rtl/spi_cc_pkg.sv
package spi_cc_pkg;
  localparam int WORD_W     = 32;
  localparam int CFG_W      = 23;
  localparam int MODCTL_OFS = 'h28;
  localparam int CH_BASE    = 'h2C;
  localparam int CH_STRIDE  = 'h14;
  localparam int OFS_CFG    = 'h0;
  localparam int OFS_STAT   = 'h4;
  localparam int OFS_CTL    = 'h8;
  localparam int OFS_TX     = 'hC;
  localparam int OFS_RX     = 'h10;

  localparam logic [CFG_W-1:0] CFG_RST = 23'h060000;

  typedef enum logic [1:0] {
    TRM_BOTH    = 2'd0,
    TRM_RX_ONLY = 2'd1,
    TRM_TX_ONLY = 2'd2,
    TRM_BAD     = 2'd3
  } trm_e;

  typedef struct packed {
    logic eot;
    logic txe;
    logic rxf;
  } stat_t;
endpackage

// File: rtl/spi_cc_chan.sv
module spi_cc_chan
  import spi_cc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_cfg_i,
  input  logic              wr_ctl_i,
  input  logic              wr_tx_i,
  input  logic              rd_rx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic [CFG_W-1:0]  cfg_o,
  output stat_t             stat_o,
  output logic              en_o,
  output logic [WORD_W-1:0] tx_o,
  output logic [WORD_W-1:0] rx_o,
  output logic [4:0]        wl_o,
  output logic              force_cs_o,
  output logic              ready_o,
  output logic              tx_dreq_o,
  output logic              rx_dreq_o
);
  logic [CFG_W-1:0]  cfg_q;
  stat_t             stat_q;
  logic              en_q;
  logic [WORD_W-1:0] tx_q, rx_q;
  trm_e              trm;
  logic              turbo, dma_tx_en, dma_rx_en;
  logic              rx_ok, tx_ok;

  assign trm       = trm_e'(cfg_q[13:12]);
  assign turbo     = cfg_q[19];
  assign dma_tx_en = cfg_q[14];
  assign dma_rx_en = cfg_q[15];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      stat_q <= '{eot: 1'b0, txe: 1'b1, rxf: 1'b0};
      en_q   <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      if (wr_cfg_i) cfg_q <= wdata_i[CFG_W-1:0];
      if (wr_ctl_i) en_q  <= wdata_i[0];
      if (wr_tx_i)  tx_q  <= wdata_i;
      if (done_i)   rx_q  <= rx_word_i;
      // new data written in the completion cycle keeps the register full
      if (wr_tx_i)      stat_q.txe <= 1'b0;
      else if (done_i)  stat_q.txe <= 1'b1;
      // fresh word arriving beats a read of the old one
      if (done_i && trm != TRM_TX_ONLY) stat_q.rxf <= 1'b1;
      else if (rd_rx_i)                 stat_q.rxf <= 1'b0;
      if (start_i)     stat_q.eot <= 1'b0;
      else if (done_i) stat_q.eot <= 1'b1;
    end
  end

  assign rx_ok   = !stat_q.rxf || trm == TRM_TX_ONLY || turbo;
  assign tx_ok   = !stat_q.txe || trm == TRM_RX_ONLY;
  assign ready_o = en_q && rx_ok && tx_ok;

  assign tx_dreq_o = en_q && dma_tx_en && stat_q.txe && trm != TRM_RX_ONLY;
  assign rx_dreq_o = en_q && dma_rx_en && stat_q.rxf && trm != TRM_TX_ONLY;

  assign wl_o       = (cfg_q[11:7] < 5'd3) ? 5'd3 : cfg_q[11:7];
  assign force_cs_o = cfg_q[20];
  assign cfg_o      = cfg_q;
  assign stat_o     = stat_q;
  assign en_o       = en_q;
  assign tx_o       = tx_q;
  assign rx_o       = rx_q;
endmodule

// File: rtl/spi_cc_arb.sv
module spi_cc_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
        found    = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/spi_cc_shift.sv
module spi_cc_shift
  import spi_cc_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [4:0]        wl_i,
  input  logic [WORD_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic              busy_q, sck_q;
  logic [DW-1:0]     div_q;
  logic [5:0]        bit_q, nb_q;
  logic [WORD_W-1:0] tx_sh, rx_sh;
  logic              tick;

  assign tick = busy_q && (div_q == DW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      nb_q   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      nb_q   <= {1'b0, wl_i} + 6'd1;
      tx_sh  <= tx_i << (5'd31 - wl_i);  // MSB of the word to bit 31
      rx_sh  <= '0;
    end else if (busy_q) begin
      div_q <= tick ? '0 : div_q + DW'(1);
      if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_sh <= {rx_sh[WORD_W-2:0], miso_i};
          bit_q <= bit_q + 6'd1;
        end else begin
          sck_q <= 1'b0;
          if (bit_q == nb_q) busy_q <= 1'b0;
          else               tx_sh  <= {tx_sh[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign done_o = tick && sck_q && (bit_q == nb_q);
  assign busy_o = busy_q;
  assign sck_o  = sck_q;
  assign mosi_o = busy_q && tx_sh[WORD_W-1];
  assign rx_o   = rx_sh;
endmodule

// File: rtl/spi_chan_ctrl.sv
module spi_chan_ctrl
  import spi_cc_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CH-1:0] cs_n_o,
  output logic [NUM_CH-1:0] tx_dreq_o,
  output logic [NUM_CH-1:0] rx_dreq_o
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              wr, rd, single_q;
  logic [NUM_CH-1:0] wr_cfg, wr_ctl, wr_tx, rd_rx;
  logic [NUM_CH-1:0] ready, gnt, start_v, done_v, force_cs, hit;
  logic [WORD_W-1:0] ch_rdata [NUM_CH];
  logic [4:0]        ch_wl    [NUM_CH];
  logic [WORD_W-1:0] ch_tx    [NUM_CH];
  logic [IDX_W-1:0]  gnt_idx, act_q;
  logic              any_ready, eng_start, eng_busy, eng_done;
  logic [WORD_W-1:0] eng_rx;

  assign wr = bus_req_i && bus_we_i;
  assign rd = bus_req_i && !bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                             single_q <= 1'b0;
    else if (wr && bus_addr_i == ADDR_W'(MODCTL_OFS))        single_q <= bus_wdata_i[0];
  end

  spi_cc_arb #(.N(NUM_CH), .IW(IDX_W)) u_arb (
    .req_i (ready),
    .gnt_o (gnt),
    .idx_o (gnt_idx),
    .any_o (any_ready)
  );

  assign eng_start = any_ready && !eng_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        act_q <= '0;
    else if (eng_start) act_q <= gnt_idx;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int B = CH_BASE + CH_STRIDE * i;
    logic [CFG_W-1:0]  cfg;
    stat_t             stat;
    logic              en;
    logic [WORD_W-1:0] rxd;

    assign wr_cfg[i]  = wr && bus_addr_i == ADDR_W'(B + OFS_CFG);
    assign wr_ctl[i]  = wr && bus_addr_i == ADDR_W'(B + OFS_CTL);
    assign wr_tx[i]   = wr && bus_addr_i == ADDR_W'(B + OFS_TX);
    assign rd_rx[i]   = rd && bus_addr_i == ADDR_W'(B + OFS_RX);
    assign start_v[i] = eng_start && gnt[i];
    assign done_v[i]  = eng_done && act_q == IDX_W'(i);

    spi_cc_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_cfg_i   (wr_cfg[i]),
      .wr_ctl_i   (wr_ctl[i]),
      .wr_tx_i    (wr_tx[i]),
      .rd_rx_i    (rd_rx[i]),
      .wdata_i    (bus_wdata_i),
      .start_i    (start_v[i]),
      .done_i     (done_v[i]),
      .rx_word_i  (eng_rx),
      .cfg_o      (cfg),
      .stat_o     (stat),
      .en_o       (en),
      .tx_o       (ch_tx[i]),
      .rx_o       (rxd),
      .wl_o       (ch_wl[i]),
      .force_cs_o (force_cs[i]),
      .ready_o    (ready[i]),
      .tx_dreq_o  (tx_dreq_o[i]),
      .rx_dreq_o  (rx_dreq_o[i])
    );

    always_comb begin
      hit[i]      = 1'b1;
      ch_rdata[i] = '0;
      if      (bus_addr_i == ADDR_W'(B + OFS_CFG))  ch_rdata[i] = {{(WORD_W-CFG_W){1'b0}}, cfg};
      else if (bus_addr_i == ADDR_W'(B + OFS_STAT)) ch_rdata[i] = {{(WORD_W-3){1'b0}}, stat};
      else if (bus_addr_i == ADDR_W'(B + OFS_CTL))  ch_rdata[i] = {{(WORD_W-1){1'b0}}, en};
      else if (bus_addr_i == ADDR_W'(B + OFS_TX))   ch_rdata[i] = ch_tx[i];
      else if (bus_addr_i == ADDR_W'(B + OFS_RX))   ch_rdata[i] = rxd;
      else                                          hit[i]      = 1'b0;
    end

    assign cs_n_o[i] = !(eng_busy && act_q == IDX_W'(i) && (!single_q || force_cs[i]));
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(MODCTL_OFS)) bus_rdata_o = {{(WORD_W-1){1'b0}}, single_q};
    for (int i = 0; i < NUM_CH; i++)
      if (hit[i]) bus_rdata_o = ch_rdata[i];
  end

  spi_cc_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (eng_start),
    .wl_i    (ch_wl[gnt_idx]),
    .tx_i    (ch_tx[gnt_idx]),
    .miso_i  (miso_i),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .rx_o    (eng_rx)
  );
endmodule

// File: rtl/spi_chan_ctrl_chk.sv
module spi_chan_ctrl_chk
  import spi_cc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 8,
  parameter int IW     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              sck_o,
  input logic              mosi_o,
  input logic [NUM_CH-1:0] cs_n_o,
  input logic [NUM_CH-1:0] tx_dreq_o,
  input logic [NUM_CH-1:0] rx_dreq_o,
  input logic              eng_busy_i,
  input logic              eng_done_i,
  input logic [IW-1:0]     act_idx_i
);
  AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o)); // R9

  AST_CS_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy_i |-> &cs_n_o); // R8

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eng_busy_i |-> !sck_o); // R10

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_busy_i && $past(eng_busy_i) && sck_o |-> $stable(mosi_o)); // R10

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    localparam int B = CH_BASE + CH_STRIDE * i;

    AST_TX_DREQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_i && bus_we_i && bus_addr_i == ADDR_W'(B + OFS_TX) |=> !tx_dreq_o[i]); // R6

    AST_RX_DREQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_i && !bus_we_i && bus_addr_i == ADDR_W'(B + OFS_RX)
      && !(eng_done_i && act_idx_i == IW'(i)) |=> !rx_dreq_o[i]); // R5
  end
endmodule

bind spi_chan_ctrl spi_chan_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .IW(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .sck_o      (sck_o),
  .mosi_o     (mosi_o),
  .cs_n_o     (cs_n_o),
  .tx_dreq_o  (tx_dreq_o),
  .rx_dreq_o  (rx_dreq_o),
  .eng_busy_i (eng_busy),
  .eng_done_i (eng_done),
  .act_idx_i  (act_q)
);

// File: tb/spi_chan_ctrl_bench.sv
`timescale 1ns/1ps
module spi_chan_ctrl_bench;
  localparam int NUM_CH = 4;
  localparam int CLK_DIV = 4;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0, bus_rdata_o;
  logic        sck_o, mosi_o, miso_i;
  logic [NUM_CH-1:0] cs_n_o, tx_dreq_o, rx_dreq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] cap, slv;
  int sck_cnt;
  logic [NUM_CH-1:0] cs_seen, cs_prev;
  int log_n;
  int cs_log [8];

  always #2 clk_i = ~clk_i;

  spi_chan_ctrl #(.NUM_CH(NUM_CH), .CLK_DIV(CLK_DIV), .ADDR_W(8)) u_spi_chan_ctrl (.*);

  assign miso_i = slv[31];
  always @(posedge sck_o) begin cap = {cap[30:0], mosi_o}; sck_cnt++; end
  always @(negedge sck_o) slv = slv << 1;
  always @(negedge clk_i) begin
    for (int i = 0; i < NUM_CH; i++)
      if (cs_prev[i] && !cs_n_o[i] && log_n < 8) begin cs_log[log_n] = i; log_n++; end
    cs_seen |= ~cs_n_o;
    cs_prev = cs_n_o;
  end

  function automatic logic [7:0] ra(int ch, int ofs);
    return 8'(8'h2C + 8'h14 * ch + ofs);
  endfunction
  localparam int CFG = 0, STA = 4, CTL = 8, TXR = 12, RXR = 16;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_req_i = 0; bus_we_i = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_req_i = 1; bus_we_i = 0; bus_addr_i = a;
    #1 d = bus_rdata_o;
    @(negedge clk_i);
    bus_req_i = 0;
  endtask

  task automatic prep(int wl, logic [31:0] sw);
    slv = sw << (31 - wl); cap = '0; sck_cnt = 0; cs_seen = '0;
  endtask

  task automatic wait_eot(int ch);
    logic [31:0] s;
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < 2000; k++) begin
      bus_rd(ra(ch, STA), s);
      if (s[2]) break;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int c = 0; c < NUM_CH; c++) begin
      bus_rd(ra(c, CFG), d); check("R1 cfg reset", d, 32'h060000);
      bus_rd(ra(c, STA), d); check("R1 status reset", d, 32'h2);
      bus_rd(ra(c, CTL), d); check("R1 enable reset", d, 32'h0);
    end
    check("R1 pins idle", {sck_o, cs_n_o, tx_dreq_o, rx_dreq_o}, {1'b0, 4'hF, 4'h0, 4'h0});
  endtask

  task automatic t_basic;
    logic [31:0] d;
    bus_wr(8'h28, 0);
    bus_wr(ra(0, CFG), 7 << 7);
    bus_wr(ra(0, CTL), 1);
    prep(7, 32'h3C);
    bus_wr(ra(0, TXR), 32'hA5);
    wait_eot(0);
    check("R2 mosi word", cap[7:0], 32'hA5);
    check("R10 sck edges", sck_cnt, 8);
    bus_rd(ra(0, STA), d); check("R3 status after word", d, 32'h7);
    check("R8 cs seen", 32'(cs_seen), 32'h1);
    bus_rd(ra(0, RXR), d); check("R2 rx word", d, 32'h3C);
    bus_rd(ra(0, STA), d); check("R5 rx read clears full", d, 32'h6);
  endtask

  task automatic t_length;
    logic [31:0] d;
    bus_wr(ra(0, CFG), 1 << 7);
    prep(3, 32'h6);
    bus_wr(ra(0, TXR), 32'h9);
    wait_eot(0);
    check("R2 clamp edges", sck_cnt, 4);
    check("R2 clamp mosi", cap[3:0], 32'h9);
    bus_rd(ra(0, RXR), d); check("R2 clamp rx", d, 32'h6);
    bus_wr(ra(0, CFG), 15 << 7);
    prep(15, 32'h1234);
    bus_wr(ra(0, TXR), 32'hBEEF);
    wait_eot(0);
    check("R2 16b mosi", cap[15:0], 32'hBEEF);
    bus_rd(ra(0, RXR), d); check("R2 16b rx", d, 32'h1234);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    bus_wr(ra(1, CFG), 7 << 7);
    prep(7, 32'h81);
    bus_wr(ra(1, TXR), 32'h55);
    repeat (60) @(negedge clk_i);
    check("R4 disabled no sck", sck_cnt, 0);
    bus_rd(ra(1, STA), d); check("R4 disabled status", d, 32'h0);
    bus_wr(ra(1, CTL), 1);
    wait_eot(1);
    check("R5 start on enable", cap[7:0], 32'h55);
    bus_rd(ra(1, RXR), d); check("R5 rx after enable", d, 32'h81);
  endtask

  task automatic t_rxfull;
    logic [31:0] d;
    prep(7, 32'h0F);
    bus_wr(ra(1, TXR), 32'h10);
    wait_eot(1);
    prep(7, 32'hF0);
    bus_wr(ra(1, TXR), 32'h11);
    repeat (60) @(negedge clk_i);
    check("R4 rx full stalls", sck_cnt, 0);
    bus_rd(ra(1, RXR), d); check("R4 old rx kept", d, 32'h0F);
    wait_eot(1);
    check("R5 read restarts", cap[7:0], 32'h11);
    bus_rd(ra(1, RXR), d); check("R5 new rx", d, 32'hF0);
    bus_wr(ra(1, CFG), (7 << 7) | (1 << 19));
    prep(7, 32'h22);
    bus_wr(ra(1, TXR), 32'h22);
    wait_eot(1);
    prep(7, 32'h44);
    bus_wr(ra(1, TXR), 32'h33);
    wait_eot(1);
    check("R4 turbo proceeds", sck_cnt, 8);
    bus_rd(ra(1, RXR), d); check("R4 turbo rx", d, 32'h44);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    bus_wr(ra(2, CFG), (7 << 7) | (2 << 12) | (1 << 15));
    bus_wr(ra(2, CTL), 1);
    prep(7, 32'h01);
    bus_wr(ra(2, TXR), 32'h5A);
    wait_eot(2);
    bus_rd(ra(2, STA), d); check("R3 tx-only status", d, 32'h6);
    check("R6 tx-only no rx dreq", 32'(rx_dreq_o[2]), 0);
    prep(7, 32'h01);
    bus_wr(ra(2, TXR), 32'h5B);
    wait_eot(2);
    check("R4 tx-only ignores rx", sck_cnt, 8);
    prep(7, 32'hC3);
    bus_wr(ra(2, CFG), (7 << 7) | (1 << 12) | (1 << 14));
    wait_eot(2);
    bus_rd(ra(2, STA), d); check("R3 rx-only status", d, 32'h7);
    check("R6 rx-only no tx dreq", 32'(tx_dreq_o[2]), 0);
    prep(7, 32'h3C);
    repeat (60) @(negedge clk_i);
    check("R4 rx-only stalls on full", sck_cnt, 0);
    bus_rd(ra(2, RXR), d); check("R2 rx-only data", d, 32'hC3);
    wait_eot(2);
    check("R5 rx-only read restarts", sck_cnt, 8);
    bus_wr(ra(2, CTL), 0);
    bus_rd(ra(2, RXR), d);
    bus_wr(ra(2, CFG), 7 << 7);
  endtask

  task automatic t_dma;
    logic [31:0] d;
    bus_wr(ra(0, CFG), (7 << 7) | (1 << 14) | (1 << 15));
    check("R6 tx dreq when empty", 32'(tx_dreq_o[0]), 1);
    check("R6 rx dreq idle", 32'(rx_dreq_o[0]), 0);
    prep(7, 32'h99);
    bus_wr(ra(0, TXR), 32'h66);
    check("R6 tx dreq drops", 32'(tx_dreq_o[0]), 0);
    wait_eot(0);
    check("R6 dreqs after word", {tx_dreq_o[0], rx_dreq_o[0]}, 2'b11);
    bus_rd(ra(0, RXR), d);
    check("R6 rx dreq drops", 32'(rx_dreq_o[0]), 0);
    bus_wr(ra(0, CTL), 0);
    check("R6 disabled no dreq", 32'(tx_dreq_o[0]), 0);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    bus_wr(ra(3, STA), 0);
    bus_rd(ra(3, STA), d); check("R7 status write ignored", d, 32'h2);
    bus_wr(ra(3, RXR), 32'hFFFF);
    bus_rd(ra(3, RXR), d); check("R7 rx write ignored", d, 32'h0);
    bus_wr(ra(3, CFG), 32'hFFFF_FFFF);
    bus_rd(ra(3, CFG), d); check("R7 cfg mask", d, 32'h7FFFFF);
    bus_wr(ra(3, CFG), 15 << 7);
    bus_rd(8'h04, d); check("R11 unmapped", d, 32'h0);
    bus_rd(8'h28, d); check("R11 module ctrl", d, 32'h0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    bus_wr(ra(1, CFG), 7 << 7);
    bus_wr(ra(2, CFG), 7 << 7);
    for (int c = 1; c < 4; c++) bus_wr(ra(c, CTL), 1);
    log_n = 0;
    prep(15, 0);
    bus_wr(ra(3, TXR), 32'h1111);
    bus_wr(ra(2, TXR), 32'h22);
    bus_wr(ra(1, TXR), 32'h11);
    repeat (200) @(negedge clk_i);
    check("R9 three words", log_n, 3);
    check("R9 order", {cs_log[0][3:0], cs_log[1][3:0], cs_log[2][3:0]}, {4'd3, 4'd1, 4'd2});
    for (int c = 1; c < 4; c++) bus_rd(ra(c, RXR), d);
  endtask

  task automatic t_cs;
    bus_wr(8'h28, 1);
    bus_wr(ra(0, CFG), 7 << 7);
    bus_wr(ra(0, CTL), 1);
    prep(7, 0);
    bus_wr(ra(0, TXR), 32'h01);
    wait_eot(0);
    check("R8 single no cs", 32'(cs_seen[0]), 0);
    bus_wr(ra(0, CFG), (7 << 7) | (1 << 20));
    begin logic [31:0] d; bus_rd(ra(0, RXR), d); end
    prep(7, 0);
    bus_wr(ra(0, TXR), 32'h02);
    wait_eot(0);
    check("R8 force cs", 32'(cs_seen[0]), 1);
  endtask

  initial begin
    cap = 0; slv = 0; sck_cnt = 0; cs_seen = 0; cs_prev = '1; log_n = 0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    t_reset;
    t_basic;
    t_length;
    t_enable;
    t_rxfull;
    t_modes;
    t_dma;
    t_readonly;
    t_priority;
    t_cs;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule